// File: doc/BRIEF.md
# Pulse-Stepped Setpoint Counter Pair

This block is the digital front end for two independent setpoint channels. One is a 5-bit brightness channel and the other is a 6-bit contrast channel. Each channel holds a code that feeds a downstream DAC, and it drives a registered section-on flag. Each channel is controlled by two asynchronous pins: an enable and an adjust strobe. Both pins pass through a two-stage synchronizer before any decision is made.

The code can only move downward. While the channel is enabled, every rising adjust edge lowers the code by one step. Stepping below zero wraps to full scale, so raising the setpoint by one step takes 2^N−1 strobes. Holding enable low with adjust high presets the code to half scale. Holding enable low with adjust low shuts the section off and keeps its code, so the setting survives shutdown.

Each channel also has a sticky error flag. The flag is set when an adjust high or low phase is shorter than the minimum width, counted in clock cycles.

Top module: `setpoint_pair`

## Requirements
- R1: After reset, the brightness code is 15, the contrast code is 31, both on flags are 0 and both error flags are 0.
- R2: While enable is high, a rising adjust edge lowers the code by one. The new code is visible after the third rising clock edge that follows the input change: two synchronizer stages, then the counter.
- R3: With enable low and adjust high, the code is preset to half scale (15 for brightness, 31 for contrast) and the on flag is 0.
- R4: A step from code 0 wraps to full scale (31 or 63). A run of 2^N−1 strobes therefore raises the code by exactly one, modulo 2^N.
- R5: With enable high and adjust static, the on flag is 1 and the code does not change.
- R6: With enable low and adjust low, the on flag is 0 and the code keeps its value. The same value is present when enable returns high.
- R7: A rising adjust edge seen while enable is low never lowers the code. Only the preset rule applies in that case.
- R8: The channel's error flag becomes 1 and stays 1 until reset in this case: after the first adjust transition since reset, an adjust phase (high or low) lasts fewer than MIN_PHASE_CYC cycles (default 5, which is 100 ns at 50 MHz). Phases of MIN_PHASE_CYC cycles or more never set it.
- R9: The channels are independent. Stimulus on one channel leaves the other channel's code, on flag and error flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brt_en | input | 1 | Brightness enable, asynchronous |
| brt_adj | input | 1 | Brightness adjust strobe, asynchronous |
| con_en | input | 1 | Contrast enable, asynchronous |
| con_adj | input | 1 | Contrast adjust strobe, asynchronous |
| brt_code | output | 5 | Brightness setpoint code |
| brt_on | output | 1 | Brightness section on |
| brt_err | output | 1 | Brightness sticky pulse-width error |
| con_code | output | 6 | Contrast setpoint code |
| con_on | output | 1 | Contrast section on |
| con_err | output | 1 | Contrast sticky pulse-width error |

## Verification
The assertions assume the following of the inputs:
- Adjust falls well before enable falls, so a channel that is being shut down never sees enable low with adjust still high. That combination is a preset by definition, and the bench produces it only on purpose.
- Each pin changes at most once per clock, so the synchronized levels carry the same phase lengths as the pins.

The bench keeps to these assumptions by changing inputs only on falling clock edges. It lowers adjust before it drops enable. It gives every legal strobe phase at least MIN_PHASE_CYC cycles, and shortens a phase only in the error tests.

// File: rtl/setpoint_pkg.sv
`timescale 1ns/1ps
package setpoint_pkg;
  // Half-scale preset code for a W-bit counter: 2^(W-1)-1
  function automatic int unsigned half_code(int unsigned w);
    return (32'd1 << (w - 1)) - 32'd1;
  endfunction

  // One downward step with wrap from zero to full scale
  function automatic int unsigned step_down(int unsigned c, int unsigned w);
    return (c == 0) ? ((32'd1 << w) - 32'd1) : (c - 32'd1);
  endfunction
endpackage

// File: rtl/sp_sync.sv
`timescale 1ns/1ps
module sp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sp_width_mon.sv
`timescale 1ns/1ps
module sp_width_mon #(
  parameter int MIN_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chg,
  output logic err
);
  localparam int CNT_W = $clog2(MIN_CYC + 1);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CYC);

  logic [CNT_W-1:0] run_cnt;
  logic             seen;
  logic             short_evt;

  // A phase ends at chg; run_cnt then holds its length in cycles
  assign short_evt = chg && seen && (run_cnt < MIN_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      seen    <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (chg)                 run_cnt <= CNT_W'(1);
      else if (run_cnt < MIN_V) run_cnt <= run_cnt + CNT_W'(1);
      if (chg) seen <= 1'b1;
      if (short_evt) err <= 1'b1;
    end
  end

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(chg));
endmodule

// File: rtl/sp_channel.sv
`timescale 1ns/1ps
module sp_channel
  import setpoint_pkg::*;
#(
  parameter int W           = 5,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_CYC     = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_a,
  input  logic         adj_a,
  output logic [W-1:0] code,
  output logic         on,
  output logic         err
);
  localparam logic [W-1:0] HALF = W'(half_code(W));

  logic [1:0] sync_q;
  logic       en_s, adj_s, adj_d;
  logic       adj_rise, adj_chg;
  logic       preset_evt, step_evt;

  sp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({en_a, adj_a}), .q(sync_q)
  );
  assign en_s  = sync_q[1];
  assign adj_s = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adj_d <= 1'b0;
    else        adj_d <= adj_s;
  end

  assign adj_rise   = adj_s && !adj_d;
  assign adj_chg    = adj_s ^ adj_d;
  assign preset_evt = !en_s && adj_s;
  assign step_evt   = en_s && adj_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= HALF;
      on   <= 1'b0;
    end else begin
      if (preset_evt)    code <= HALF;
      else if (step_evt) code <= W'(step_down(32'(code), W));
      on <= en_s;
    end
  end

  sp_width_mon #(.MIN_CYC(MIN_CYC)) u_mon (
    .clk(clk), .rst_n(rst_n), .chg(adj_chg), .err(err)
  );

  assert_preset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    preset_evt |=> (code == HALF) && !on);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> code == W'(step_down(32'($past(code)), W)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset_evt && !step_evt) |=> $stable(code));
  assert_no_step_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (code == $past(code)) || (code == HALF));
endmodule

// File: rtl/setpoint_pair.sv
`timescale 1ns/1ps
module setpoint_pair #(
  parameter int BRT_W         = 5,
  parameter int CON_W         = 6,
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_PHASE_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             brt_en,
  input  logic             brt_adj,
  input  logic             con_en,
  input  logic             con_adj,
  output logic [BRT_W-1:0] brt_code,
  output logic             brt_on,
  output logic             brt_err,
  output logic [CON_W-1:0] con_code,
  output logic             con_on,
  output logic             con_err
);
  sp_channel #(.W(BRT_W), .SYNC_STAGES(SYNC_STAGES), .MIN_CYC(MIN_PHASE_CYC)) u_brt (
    .clk(clk), .rst_n(rst_n), .en_a(brt_en), .adj_a(brt_adj),
    .code(brt_code), .on(brt_on), .err(brt_err)
  );

  sp_channel #(.W(CON_W), .SYNC_STAGES(SYNC_STAGES), .MIN_CYC(MIN_PHASE_CYC)) u_con (
    .clk(clk), .rst_n(rst_n), .en_a(con_en), .adj_a(con_adj),
    .code(con_code), .on(con_on), .err(con_err)
  );
endmodule

// File: tb/tb_setpoint_pair.sv
`timescale 1ns/1ps
module tb_setpoint_pair;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic brt_en = 1'b0, brt_adj = 1'b0, con_en = 1'b0, con_adj = 1'b0;
  logic [4:0] brt_code;
  logic [5:0] con_code;
  logic brt_on, brt_err, con_on, con_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int exp_b, exp_c, keep;

  always #10 clk = ~clk;

  setpoint_pair dut (
    .clk(clk), .rst_n(rst_n), .brt_en(brt_en), .brt_adj(brt_adj),
    .con_en(con_en), .con_adj(con_adj), .brt_code(brt_code), .brt_on(brt_on),
    .brt_err(brt_err), .con_code(con_code), .con_on(con_on), .con_err(con_err)
  );

  function automatic int dn(int c, int w);
    return (c + (1 << w) - 1) % (1 << w);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_b(int hi, int lo);
    brt_adj = 1'b1; wait_cyc(hi);
    brt_adj = 1'b0; wait_cyc(lo);
  endtask

  task automatic pulse_c(int hi, int lo);
    con_adj = 1'b1; wait_cyc(hi);
    con_adj = 1'b0; wait_cyc(lo);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wait_cyc(3);
    rst_n = 1'b1; wait_cyc(1);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_cyc(1);
    do_reset();
    // R1 reset state
    check("R1 brt_code", brt_code, 15);
    check("R1 con_code", con_code, 31);
    check("R1 brt_on", brt_on, 0);
    check("R1 con_on", con_on, 0);
    check("R1 brt_err", brt_err, 0);
    check("R1 con_err", con_err, 0);

    // R5 enable, static adjust
    brt_en = 1'b1; con_en = 1'b1; wait_cyc(6);
    check("R5 brt_on", brt_on, 1);
    check("R5 con_on", con_on, 1);
    check("R5 brt_code held", brt_code, 15);
    check("R5 con_code held", con_code, 31);

    // R2 latency: change at a negedge, new code after third posedge
    brt_adj = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R2 before third edge", brt_code, 15);
    @(posedge clk); @(negedge clk);
    check("R2 after third edge", brt_code, 14);
    wait_cyc(3); brt_adj = 1'b0; wait_cyc(5);
    exp_b = 14;

    // R4 brightness sweep through wrap
    for (int i = 0; i < 40; i++) begin
      pulse_b(5, 5);
      exp_b = dn(exp_b, 5);
      check("R4 brt sweep", brt_code, exp_b);
    end
    check("R9 con untouched by brt", con_code, 31);

    // R4 contrast sweep through wrap
    exp_c = 31;
    for (int i = 0; i < 70; i++) begin
      pulse_c(5, 5);
      exp_c = dn(exp_c, 6);
      check("R4 con sweep", con_code, exp_c);
    end
    check("R9 brt untouched by con", brt_code, exp_b);
    check("R8 no err on legal brt phases", brt_err, 0);
    check("R8 no err on legal con phases", con_err, 0);

    // R4 raise by one via 2^N-1 strobes
    keep = exp_b;
    for (int i = 0; i < 31; i++) pulse_b(5, 5);
    exp_b = (keep + 1) % 32;
    check("R4 brt raise by one", brt_code, exp_b);
    keep = exp_c;
    for (int i = 0; i < 63; i++) pulse_c(5, 5);
    exp_c = (keep + 1) % 64;
    check("R4 con raise by one", con_code, exp_c);

    // R6 shutdown hold and restore
    brt_en = 1'b0; wait_cyc(6);
    check("R6 brt_on off", brt_on, 0);
    check("R6 brt code held off", brt_code, exp_b);
    check("R9 con_on unaffected", con_on, 1);
    brt_en = 1'b1; wait_cyc(6);
    check("R6 brt_on restored", brt_on, 1);
    check("R6 brt code restored", brt_code, exp_b);

    // R7 / R3: rising adjust with enable low presets, never steps
    brt_en = 1'b0; wait_cyc(6);
    pulse_b(6, 6);
    check("R7 no step while off", brt_code, 15);
    check("R7 brt_on off", brt_on, 0);
    exp_b = 15;
    con_en = 1'b0; wait_cyc(6);
    con_adj = 1'b1; wait_cyc(6);
    check("R3 con preset", con_code, 31);
    check("R3 con_on off", con_on, 0);
    con_adj = 1'b0; wait_cyc(6);
    check("R3 con held after preset", con_code, 31);
    exp_c = 31;
    brt_en = 1'b1; con_en = 1'b1; wait_cyc(6);

    // R8 short high phase on brightness
    check("R8 brt_err clear before", brt_err, 0);
    pulse_b(4, 6);
    exp_b = dn(exp_b, 5);
    check("R8 brt_err set", brt_err, 1);
    check("R8 short pulse still steps", brt_code, exp_b);
    check("R9 con_err unaffected", con_err, 0);
    // R8 short low phase on contrast
    pulse_c(5, 3);
    pulse_c(5, 5);
    check("R8 con_err set", con_err, 1);
    pulse_b(6, 6);
    pulse_c(6, 6);
    check("R8 brt_err sticky", brt_err, 1);
    check("R8 con_err sticky", con_err, 1);

    // R1 reset clears errors and presets codes
    brt_en = 1'b0; con_en = 1'b0; wait_cyc(2);
    do_reset();
    check("R1 brt_err after reset", brt_err, 0);
    check("R1 con_err after reset", con_err, 0);
    check("R1 brt_code after reset", brt_code, 15);
    check("R1 con_code after reset", con_code, 31);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule